// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block decides which of five interrupt sources an 8-bit microcontroller core services next, and at which code address. The sources are two external interrupt lines, two timer overflow flags and one serial port flag. The serial flag is the OR of a receive-done and a transmit-done flag. Software programs an enable register and a level register. At one state of every machine cycle the core pulses a strobe, and at that pulse the block captures all source flags. In the clock that follows it picks a winner. If one exists and nothing blocks it, the block raises a vector request together with the fixed entry address of that source.

The core answers with an acknowledge once it has pushed the program counter and is ready to jump. On that acknowledge the block emits a one-hot pulse naming the serviced source, so the flag owner can clear its flag, and marks the winning level as in service. A return-from-interrupt pulse from the core takes one level out of service. There are two levels, and a fixed order decides between sources of the same level.

Top module: `irq_arbiter`

## Requirements
- R1: After reset the vector request, the source acknowledge and both in-service levels are 0, and both control registers are 0, so no source is enabled.
- R2: Enable register: bit 7 is the global enable and bits 4..0 enable the sources, in the index order external 0 (bit 0), timer 0 (bit 1), external 1 (bit 2), timer 1 (bit 3), serial (bit 4). Bits 6..5 are ignored. With bit 7 at 0 no request is raised, and a source whose bit is 0 is never chosen.
- R3: The vector address for source index i is 0003h + 8*i: 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R4: Flags are captured only at the clock edge where the state strobe is 1. Polling uses those captured values at the next edge, so the request first shows two edges after the strobe. A flag that is present only between strobes is never seen.
- R5: Level register: bits 4..0, using the index order of R2, with 1 meaning high level. Bits 7..5 are ignored. A pending high-level source wins over any pending low-level source.
- R6: Among pending sources of the same level, the lowest index wins.
- R7: While a low level is in service, only a high-level source can be accepted. While the high level is in service, nothing is accepted.
- R8: A return-from-interrupt pulse clears the high in-service level if it is set, otherwise the low one. With neither level set it changes nothing.
- R9: Once raised, the vector request and its address stay fixed until core_ack. In the core_ack cycle, src_ack is the one-hot of the winner. At the next edge the request drops and the winner's level enters service.
- R10: When core_block is 1 at the poll edge, no request is raised for that poll.
- R11: The serial source is pending when either serial receive or serial transmit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| state_strobe | input | 1 | Once-per-machine-cycle flag capture strobe |
| flag_in | input | 4 | External 0, timer 0, external 1, timer 1 flags (bits 0..3) |
| ser_rx | input | 1 | Serial receive-done flag |
| ser_tx | input | 1 | Serial transmit-done flag |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| lvl_we | input | 1 | Level register write strobe |
| lvl_wdata | input | 8 | Level register write data |
| reti_pulse | input | 1 | Return-from-interrupt from the core |
| core_block | input | 1 | Core forbids a new request at this poll |
| core_ack | input | 1 | Core accepts the pending vector |
| vec_req | output | 1 | Hardware call request |
| vec_addr | output | 16 | Entry address of the requested source |
| src_ack | output | 5 | One-hot serviced source, valid during core_ack |

## Verification
A corrupted in-service level changes which later polls are refused. A stuck low level shuts out same-level sources until a return pulse that should not be needed, and a stuck high level shuts out everything. The bench keeps its own level model and polls right after each acknowledge and each return, so such an error shows at vec_req within two clocks of the next strobe. A wrong capture point or a wrong priority shows at the first poll as a wrong vec_addr or a missing request. A wrong hold shows in the cycles before core_ack.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NSRC  = 5;
  localparam int IDX_W = $clog2(NSRC);

  // lowest-numbered set bit wins (fixed in-level polling order)
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NSRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [31:0] vector_for(input logic [IDX_W-1:0] idx,
                                             input int base, input int stride);
    return 32'(base) + 32'(idx) * 32'(stride);
  endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler
  import irq_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] held,
  output logic            poll_now
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= '0;
      poll_now <= 1'b0;
    end else begin
      poll_now <= strobe;
      if (strobe) held <= raw;
    end
  end
endmodule

// File: rtl/irq_picker.sv
module irq_picker
  import irq_arb_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  lvl,
  input  logic             ip_hi,
  input  logic             ip_lo,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             pick_hi
);
  logic [NSRC-1:0] hi_v, lo_v;
  logic hi_ok, lo_ok;

  for (genvar g = 0; g < NSRC; g++) begin : g_split
    assign hi_v[g] = pend[g] & lvl[g];
    assign lo_v[g] = pend[g] & ~lvl[g];
  end

  assign hi_ok = (|hi_v) & ~ip_hi;
  assign lo_ok = (|lo_v) & ~ip_hi & ~ip_lo;

  always_comb begin
    hit     = hi_ok | lo_ok;
    pick_hi = hi_ok;
    idx     = hi_ok ? lowest_set(hi_v) : lowest_set(lo_v);
  end
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic reti,
  output logic ip_hi,
  output logic ip_lo
);
  logic nx_hi, nx_lo;

  always_comb begin
    nx_hi = ip_hi;
    nx_lo = ip_lo;
    if (reti) begin
      if (ip_hi) nx_hi = 1'b0;
      else       nx_lo = 1'b0;
    end
    if (take) begin
      if (take_hi) nx_hi = 1'b1;
      else         nx_lo = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip_hi <= 1'b0;
      ip_lo <= 1'b0;
    end else begin
      ip_hi <= nx_hi;
      ip_lo <= nx_lo;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int REG_W      = 8,
  parameter int GLB_BIT    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              state_strobe,
  input  logic [3:0]        flag_in,
  input  logic              ser_rx,
  input  logic              ser_tx,
  input  logic              en_we,
  input  logic [REG_W-1:0]  en_wdata,
  input  logic              lvl_we,
  input  logic [REG_W-1:0]  lvl_wdata,
  input  logic              reti_pulse,
  input  logic              core_block,
  input  logic              core_ack,
  output logic              vec_req,
  output logic [ADDR_W-1:0] vec_addr,
  output logic [NSRC-1:0]   src_ack
);
  logic [NSRC-1:0]  raw_flags, held_flags, pending;
  logic [NSRC-1:0]  en_src, lvl_src;
  logic             glb_en;
  logic             poll_now;
  logic             g_hit, g_hi;
  logic [IDX_W-1:0] g_idx;
  logic [IDX_W-1:0] win_idx;
  logic             win_hi;
  logic             accept, take;
  logic             ip_hi, ip_lo;
  logic             unused_rsvd;

  assign unused_rsvd = ^{en_wdata[GLB_BIT-1:NSRC], lvl_wdata[REG_W-1:NSRC]};

  assign raw_flags = {ser_rx | ser_tx, flag_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_src  <= '0;
      glb_en  <= 1'b0;
      lvl_src <= '0;
    end else begin
      if (en_we) begin
        glb_en <= en_wdata[GLB_BIT];
        en_src <= en_wdata[NSRC-1:0];
      end
      if (lvl_we) lvl_src <= lvl_wdata[NSRC-1:0];
    end
  end

  irq_sampler u_samp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (state_strobe),
    .raw      (raw_flags),
    .held     (held_flags),
    .poll_now (poll_now)
  );

  assign pending = held_flags & en_src & {NSRC{glb_en}};

  irq_picker u_pick (
    .pend    (pending),
    .lvl     (lvl_src),
    .ip_hi   (ip_hi),
    .ip_lo   (ip_lo),
    .hit     (g_hit),
    .idx     (g_idx),
    .pick_hi (g_hi)
  );

  assign accept = poll_now & g_hit & ~vec_req & ~core_block;
  assign take   = vec_req & core_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_req  <= 1'b0;
      vec_addr <= '0;
      win_idx  <= '0;
      win_hi   <= 1'b0;
    end else if (take) begin
      vec_req <= 1'b0;
    end else if (accept) begin
      vec_req  <= 1'b1;
      vec_addr <= ADDR_W'(vector_for(g_idx, VEC_BASE, VEC_STRIDE));
      win_idx  <= g_idx;
      win_hi   <= g_hi;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_ack
    assign src_ack[g] = take & (win_idx == IDX_W'(g));
  end

  irq_level_track u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .take_hi (win_hi),
    .reti    (reti_pulse),
    .ip_hi   (ip_hi),
    .ip_lo   (ip_lo)
  );
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vec_req,
  input logic [ADDR_W-1:0] vec_addr,
  input logic [NSRC-1:0]   src_ack,
  input logic              core_ack,
  input logic              core_block,
  input logic              reti_pulse,
  input logic              poll_now,
  input logic              glb_en,
  input logic              ip_hi,
  input logic              ip_lo
);
  logic take;
  assign take = vec_req & core_ack;

  assert_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req && !core_ack |=> vec_req && $stable(vec_addr));

  assert_ack_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack) && ((src_ack != '0) == take));

  assert_take_enters_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !vec_req && (ip_hi || ip_lo));

  assert_poll_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_req) |-> $past(poll_now));

  assert_global_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_req) |-> $past(glb_en));

  assert_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    poll_now && core_block && !vec_req |=> !vec_req);

  assert_hi_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_req) |-> !$past(ip_hi));

  assert_reti_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reti_pulse && ip_hi && !take |=> !ip_hi && (ip_lo == $past(ip_lo)));

  assert_reti_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reti_pulse && !ip_hi && ip_lo && !take |=> !ip_lo && !ip_hi);

  assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ((int'(vec_addr) - VEC_BASE) % VEC_STRIDE == 0) &&
                (int'(vec_addr) <= VEC_BASE + (NSRC - 1) * VEC_STRIDE));
endmodule

bind irq_arbiter irq_arbiter_chk #(
  .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .vec_req    (vec_req),
  .vec_addr   (vec_addr),
  .src_ack    (src_ack),
  .core_ack   (core_ack),
  .core_block (core_block),
  .reti_pulse (reti_pulse),
  .poll_now   (poll_now),
  .glb_en     (glb_en),
  .ip_hi      (ip_hi),
  .ip_lo      (ip_lo)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        state_strobe = 1'b0;
  logic [3:0]  flag_in = '0;
  logic        ser_rx = 1'b0, ser_tx = 1'b0;
  logic        en_we = 1'b0, lvl_we = 1'b0;
  logic [7:0]  en_wdata = '0, lvl_wdata = '0;
  logic        reti_pulse = 1'b0, core_block = 1'b0, core_ack = 1'b0;
  logic        vec_req;
  logic [15:0] vec_addr;
  logic [4:0]  src_ack;

  int n_chk = 0, n_bad = 0;
  logic [7:0] en_m = '0, lvl_m = '0;
  bit ih_m = 0, il_m = 0;

  always #10 clk = ~clk;

  irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .state_strobe(state_strobe), .flag_in(flag_in),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .en_we(en_we), .en_wdata(en_wdata),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .reti_pulse(reti_pulse),
    .core_block(core_block), .core_ack(core_ack), .vec_req(vec_req),
    .vec_addr(vec_addr), .src_ack(src_ack)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  // independent model: high level first, then low, index order inside a level
  function automatic int exp_win(input logic [4:0] f);
    if (!en_m[7] || ih_m) return -1;
    for (int i = 0; i < 5; i++) if (f[i] && en_m[i] && lvl_m[i]) return i;
    if (il_m) return -1;
    for (int i = 0; i < 5; i++) if (f[i] && en_m[i] && !lvl_m[i]) return i;
    return -1;
  endfunction

  task automatic wr_en(input logic [7:0] v);
    @(negedge clk); en_we = 1; en_wdata = v;
    @(negedge clk); en_we = 0; en_m = v;
  endtask

  task automatic wr_lvl(input logic [7:0] v);
    @(negedge clk); lvl_we = 1; lvl_wdata = v;
    @(negedge clk); lvl_we = 0; lvl_m = v;
  endtask

  task automatic do_reti();
    @(negedge clk); reti_pulse = 1;
    @(negedge clk); reti_pulse = 0;
    if (ih_m) ih_m = 0; else il_m = 0;
  endtask

  task automatic serve(input int w, input string rq);
    core_ack = 1;
    #1;
    chk(src_ack == 5'(1 << w), rq, "src_ack on core_ack", src_ack, 1 << w);
    @(negedge clk); core_ack = 0;
    chk(vec_req == 0, rq, "request dropped after ack", vec_req, 0);
    chk(src_ack == 0, rq, "src_ack after ack", src_ack, 0);
    if (lvl_m[w]) ih_m = 1; else il_m = 1;
  endtask

  // strobe with flags, drop flags, poll edge, check at negedge after poll
  task automatic poll(input logic [3:0] f, input logic rx, input logic tx,
                      input bit blk, input bit ack, input string rq);
    int w;
    w = blk ? -1 : exp_win({rx | tx, f});
    @(negedge clk); flag_in = f; ser_rx = rx; ser_tx = tx; state_strobe = 1;
    @(negedge clk); state_strobe = 0; flag_in = 0; ser_rx = 0; ser_tx = 0;
    core_block = blk;
    chk(vec_req == 0, rq, "no request one edge after strobe", vec_req, 0);
    @(negedge clk); core_block = 0;
    chk(vec_req == (w >= 0), rq, "request after poll", vec_req, w >= 0);
    if (w >= 0) begin
      chk(vec_addr == 16'(3 + 8 * w), rq, "vector address", vec_addr, 3 + 8 * w);
      if (ack) serve(w, rq);
    end
  endtask

  task automatic t_reset();
    chk(vec_req == 0, "R1", "vec_req at reset", vec_req, 0);
    chk(src_ack == 0, "R1", "src_ack at reset", src_ack, 0);
    poll(4'hF, 1, 0, 0, 1, "R1");
  endtask

  task automatic t_global();
    wr_en(8'h1F);
    poll(4'h1, 0, 0, 0, 1, "R2");   // global off: nothing
    wr_en(8'hE1);                   // reserved bits set, only ext0 enabled
    poll(4'h1, 0, 0, 0, 1, "R2");
    do_reti();
    poll(4'h2, 0, 0, 0, 1, "R2");   // timer0 disabled: nothing
  endtask

  task automatic t_order();
    wr_en(8'h9F); wr_lvl(8'h00);
    poll(4'hE, 1, 0, 0, 1, "R6"); do_reti();
    poll(4'hC, 1, 0, 0, 1, "R6"); do_reti();
    poll(4'hF, 1, 0, 0, 1, "R6"); do_reti();
    poll(4'h8, 0, 0, 0, 1, "R3"); do_reti();
    poll(4'h0, 1, 0, 0, 1, "R3"); do_reti();
    wr_en(8'h9D);
    poll(4'h6, 0, 0, 0, 1, "R2"); do_reti();
  endtask

  task automatic t_level();
    wr_en(8'h9F); wr_lvl(8'hF0);   // reserved level bits ignored
    poll(4'h1, 1, 0, 0, 1, "R5"); do_reti();
    wr_lvl(8'h08);
    poll(4'hF, 1, 0, 0, 1, "R5"); do_reti();
  endtask

  task automatic t_preempt();
    wr_lvl(8'h08);
    poll(4'h2, 0, 0, 0, 1, "R7");   // low accepted
    poll(4'h1, 0, 0, 0, 1, "R7");   // low blocked by low
    poll(4'h8, 0, 0, 0, 1, "R7");   // high preempts
    poll(4'h9, 1, 0, 0, 1, "R7");   // all blocked by high
    do_reti();                      // R8: clears high only
    poll(4'h1, 0, 0, 0, 1, "R8");   // low still in service
    do_reti();
    poll(4'h1, 0, 0, 0, 1, "R8");
    do_reti();
  endtask

  task automatic t_reti_idle();
    do_reti();                      // nothing in service
    poll(4'h1, 0, 0, 0, 1, "R8");
    poll(4'h2, 0, 0, 0, 1, "R8");   // low level must still block
    do_reti();
  endtask

  task automatic t_sample();
    @(negedge clk); state_strobe = 1;
    @(negedge clk); state_strobe = 0; flag_in = 4'h1;
    @(negedge clk); flag_in = 0;
    chk(vec_req == 0, "R4", "flag between strobes ignored", vec_req, 0);
    repeat (3) @(negedge clk);
    chk(vec_req == 0, "R4", "still no request later", vec_req, 0);
  endtask

  task automatic t_block();
    poll(4'h4, 0, 0, 1, 1, "R10");
    poll(4'h4, 0, 0, 0, 1, "R10");
    do_reti();
  endtask

  task automatic t_hold();
    poll(4'h4, 0, 0, 0, 0, "R9");
    @(negedge clk); flag_in = 4'h1; state_strobe = 1;
    @(negedge clk); flag_in = 0; state_strobe = 0;
    repeat (3) @(negedge clk);
    chk(vec_req == 1, "R9", "request held without ack", vec_req, 1);
    chk(vec_addr == 16'h0013, "R9", "address held", vec_addr, 16'h13);
    serve(2, "R9");
    do_reti();
  endtask

  task automatic t_serial();
    wr_lvl(8'h00);
    poll(4'h0, 0, 1, 0, 1, "R11"); do_reti();
    poll(4'h0, 1, 0, 0, 1, "R11"); do_reti();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_global();
    t_order();
    t_level();
    t_preempt();
    t_reti_idle();
    t_sample();
    t_block();
    t_hold();
    t_serial();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule